// File: doc/BRIEF.md
# Address-Dependent Bus Cycle-Length Generator

The block decides how many master clock cycles a CPU bus access lasts and advances a master clock counter to match. Each accepted access address is split into a bank (the top byte) and a page (the next byte). These two fields select a length of 6, 8 or 12 master cycles. A fast-ROM enable selects the short timing for the upper ROM regions.

The counter moves in steps of 2 master cycles, one step per cycle of `clk`. A dot-clock enable is derived from it and fires each time the counter lands on a multiple of 4. An external stall request can insert extra steps while no access is running, so that other logic can account for bus stalls.

The sequencer has three states:
- `ST_IDLE` waits for work and is the only state in which `acc_ready` is high.
- `ST_ACCESS` counts down the steps that remain in the current access.
- `ST_STALL` adds one step for each cycle that the stall request stays high.

The transitions are:
- IDLE→STALL when `stall_req` is high. This takes priority over an access.
- IDLE→ACCESS when `acc_valid` is high and `stall_req` is low.
- ACCESS→ACCESS while more than one step remains.
- ACCESS→IDLE on the last step. This transition raises `acc_done`.
- STALL→STALL while `stall_req` stays high.
- STALL→IDLE when `stall_req` falls.

Top module: `bus_cycle_timer`

## Requirements
- R1: After reset `master_clk` is 0, `acc_ready` is 1, and `acc_done` and `dot_en` are 0.
- R2: An address whose bank is 0x40–0x7F lasts 8 master cycles, whatever `fast_rom` is.
- R3: An address whose bank is 0xC0–0xFF lasts 6 master cycles when `fast_rom` is 1 and 8 when it is 0.
- R4: In banks 0x00–0x3F and 0x80–0xBF, the length depends on the page (address bits 15:8):
  - pages 0x00–0x1F last 8 master cycles;
  - pages 0x20–0x3F last 6;
  - pages 0x40–0x5F last 12;
  - pages 0x60–0x7F last 8.
- R5: Pages 0x80–0xFF have two cases:
  - in banks 0x00–0x3F they last 8 master cycles;
  - in banks 0x80–0xBF they last 6 when `fast_rom` is 1 and 8 when it is 0.
- R6: An access of N master cycles is accepted on a rising edge of `clk`.
  - That edge, and each of the next N/2−1 edges, adds 2 to `master_clk`.
  - `acc_done` is high for exactly the one cycle that follows the last of those edges.
- R7: `dot_en` is high for the one cycle that follows each edge on which `master_clk` changes to a multiple of 4. It is low at all other times.
- R8: An access is accepted only while `acc_ready` is 1.
  - The address and `fast_rom` are captured at acceptance, so later changes do not alter the running access.
  - A new access can be accepted in the cycle in which `acc_done` is high.
- R9: In `ST_IDLE`, `stall_req` takes priority over `acc_valid`.
  - Each edge with `stall_req` high adds 2 to `master_clk` and completes no access.
  - After `stall_req` falls, one further edge returns the block to ready without a step.
- R10: While the block is idle and both `acc_valid` and `stall_req` are low, `master_clk` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock; one step of 2 master cycles per active cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Request to start an access at `acc_addr` |
| acc_addr | input | 24 | Access address; bits 23:16 are the bank, bits 15:8 the page |
| fast_rom | input | 1 | Selects 6-cycle timing for the upper ROM regions |
| stall_req | input | 1 | Inserts one step per cycle while the block is idle or stalled |
| master_clk | output | 32 | Master clock count, advanced in steps of 2 |
| acc_done | output | 1 | One-cycle pulse after the last step of an access |
| acc_ready | output | 1 | High when a new access or stall can be taken |
| dot_en | output | 1 | One-cycle enable after each step that lands on a multiple of 4 |

## Verification
`master_clk` moves on the acceptance edge itself and on every following step edge. `acc_done` is due at the N/2-th falling edge after the inputs are applied. The bench therefore drives inputs on a falling edge and counts falling edges until `acc_done` appears. At that point it compares the count with N/2 and the change in `master_clk` with N.

`dot_en` is registered on the same edge as the step. A falling-edge monitor therefore expects it exactly when `master_clk` has changed since the previous falling edge and its low two bits are zero.

Stall and idle checks sample `master_clk` one falling edge after each change of `stall_req`. That edge is where the step, or the single recovery cycle, becomes visible.

// File: rtl/bct_pkg.sv
package bct_pkg;

    // access lengths in master cycles
    localparam int FAST_MC  = 6;
    localparam int SLOW_MC  = 8;
    localparam int XSLOW_MC = 12;
    // master cycles per internal step
    localparam int STEP_MC  = 2;
    // width of the per-access step counter
    localparam int CNT_W    = $clog2(XSLOW_MC / STEP_MC + 1);

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACCESS = 2'd1,
        ST_STALL  = 2'd2
    } bct_state_e;

    typedef enum logic [1:0] {
        SPD_FAST  = 2'd0,
        SPD_SLOW  = 2'd1,
        SPD_XSLOW = 2'd2
    } bct_speed_e;

    function automatic logic [CNT_W-1:0] speed_steps(bct_speed_e s);
        logic [CNT_W-1:0] r;
        unique case (s)
            SPD_FAST:  r = CNT_W'(FAST_MC / STEP_MC);
            SPD_SLOW:  r = CNT_W'(SLOW_MC / STEP_MC);
            SPD_XSLOW: r = CNT_W'(XSLOW_MC / STEP_MC);
            default:   r = CNT_W'(SLOW_MC / STEP_MC);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/bct_decode.sv
module bct_decode
    import bct_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              fast_rom,
    output bct_speed_e        speed
);

    localparam int BANK_HI = ADDR_W - 1;
    localparam int PAGE_HI = ADDR_W - 9;

    logic [7:0] bank;
    logic [7:0] page;
    logic       upper_half;   // banks 0x80-0xFF
    logic       rom_region;   // banks 0x40-0x7F / 0xC0-0xFF

    assign bank       = addr[BANK_HI -: 8];
    assign page       = addr[PAGE_HI -: 8];
    assign upper_half = bank[7];
    assign rom_region = bank[6];

    always_comb begin
        speed = SPD_SLOW;
        if (rom_region) begin
            if (upper_half && fast_rom) speed = SPD_FAST;
            else                        speed = SPD_SLOW;
        end else begin
            unique case (page[7:5])
                3'b000:  speed = SPD_SLOW;
                3'b001:  speed = SPD_FAST;
                3'b010:  speed = SPD_XSLOW;
                3'b011:  speed = SPD_SLOW;
                default: speed = (upper_half && fast_rom) ? SPD_FAST : SPD_SLOW;
            endcase
        end
    end

endmodule

// File: rtl/bct_master_clk.sv
module bct_master_clk
    import bct_pkg::*;
#(
    parameter int MC_W    = 32,
    parameter int DOT_DIV = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step,
    output logic [MC_W-1:0] master_clk,
    output logic            dot_en
);

    localparam logic [MC_W-1:0] STEP_VAL = MC_W'(STEP_MC);
    localparam logic [MC_W-1:0] DOT_MASK = MC_W'(DOT_DIV - 1);

    logic [MC_W-1:0] next_clk;

    assign next_clk = master_clk + STEP_VAL;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_clk <= '0;
            dot_en     <= 1'b0;
        end else if (step) begin
            master_clk <= next_clk;
            dot_en     <= ((next_clk & DOT_MASK) == '0);
        end else begin
            dot_en     <= 1'b0;
        end
    end

endmodule

// File: rtl/bct_seq.sv
module bct_seq
    import bct_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             stall_req,
    input  logic [CNT_W-1:0] steps_in,
    output logic             step,
    output logic             acc_done,
    output logic             acc_ready
);

    bct_state_e       st, st_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt;
    logic             done_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            cnt      <= '0;
            acc_done <= 1'b0;
        end else begin
            st       <= st_nxt;
            cnt      <= cnt_nxt;
            acc_done <= done_nxt;
        end
    end

    // next state and outputs
    always_comb begin
        st_nxt   = st;
        cnt_nxt  = cnt;
        done_nxt = 1'b0;
        step     = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (stall_req) begin
                    step   = 1'b1;
                    st_nxt = ST_STALL;
                end else if (acc_valid) begin
                    step    = 1'b1;
                    cnt_nxt = steps_in - CNT_W'(1);
                    st_nxt  = ST_ACCESS;
                end
            end
            ST_ACCESS: begin
                step = 1'b1;
                if (cnt == CNT_W'(1)) begin
                    st_nxt   = ST_IDLE;
                    done_nxt = 1'b1;
                    cnt_nxt  = '0;
                end else begin
                    cnt_nxt = cnt - CNT_W'(1);
                end
            end
            ST_STALL: begin
                if (stall_req) step = 1'b1;
                else           st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    assign acc_ready = (st == ST_IDLE);

endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer
    import bct_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int MC_W    = 32,
    parameter int DOT_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              fast_rom,
    input  logic              stall_req,
    output logic [MC_W-1:0]   master_clk,
    output logic              acc_done,
    output logic              acc_ready,
    output logic              dot_en
);

    bct_speed_e       speed;
    logic [CNT_W-1:0] steps;
    logic             step;

    bct_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr     (acc_addr),
        .fast_rom (fast_rom),
        .speed    (speed)
    );

    assign steps = speed_steps(speed);

    bct_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .stall_req (stall_req),
        .steps_in  (steps),
        .step      (step),
        .acc_done  (acc_done),
        .acc_ready (acc_ready)
    );

    bct_master_clk #(.MC_W(MC_W), .DOT_DIV(DOT_DIV)) u_mclk (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (step),
        .master_clk (master_clk),
        .dot_en     (dot_en)
    );

endmodule

// File: rtl/bct_checker.sv
module bct_checker #(
    parameter int MC_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            acc_valid,
    input logic            stall_req,
    input logic [MC_W-1:0] master_clk,
    input logic            acc_done,
    input logic            acc_ready,
    input logic            dot_en
);

    // R6: the counter moves by 0 or by exactly one step
    assert_step_size_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (master_clk == $past(master_clk)) || (master_clk == $past(master_clk) + MC_W'(2)));

    // R6: the completion pulse lasts one cycle
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |=> !acc_done);

    // R8: completion is seen with the block ready for more work
    assert_done_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_done |-> acc_ready);

    // R8: a request taken while ready leaves the ready state
    assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ready && acc_valid && !stall_req) |=> !acc_ready);

    // R7: the dot enable follows a step onto a multiple of 4
    assert_dot_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dot_en |-> ((master_clk[1:0] == 2'b00) && (master_clk != $past(master_clk))));

    // R10: nothing requested while idle keeps the counter still
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ready && !acc_valid && !stall_req) |=> $stable(master_clk));

    // R9: a stall in idle never completes an access
    assert_stall_no_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ready && stall_req) |=> !acc_done);

endmodule

bind bus_cycle_timer bct_checker #(.MC_W(MC_W)) u_bct_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .stall_req  (stall_req),
    .master_clk (master_clk),
    .acc_done   (acc_done),
    .acc_ready  (acc_ready),
    .dot_en     (dot_en)
);

// File: tb/tb_bus_cycle_timer.sv
module tb_bus_cycle_timer;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 15;

    // {fast_rom, addr[23:0], length in master cycles}
    localparam logic [32:0] VECS [NVEC] = '{
        {1'b0, 24'h400000, 8'd8},   // R2
        {1'b1, 24'h7FFFFF, 8'd8},   // R2
        {1'b1, 24'hC00000, 8'd6},   // R3
        {1'b0, 24'hFF8000, 8'd8},   // R3
        {1'b1, 24'h001F00, 8'd8},   // R4
        {1'b0, 24'h002000, 8'd6},   // R4
        {1'b0, 24'h803F00, 8'd6},   // R4
        {1'b1, 24'h3F4000, 8'd12},  // R4
        {1'b0, 24'h805F00, 8'd12},  // R4
        {1'b1, 24'h006000, 8'd8},   // R4
        {1'b1, 24'hBF7F00, 8'd8},   // R4
        {1'b1, 24'h008000, 8'd8},   // R5
        {1'b0, 24'h3FFF00, 8'd8},   // R5
        {1'b1, 24'h808000, 8'd6},   // R5
        {1'b0, 24'hBFFF00, 8'd8}    // R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic [23:0] acc_addr = '0;
    logic        fast_rom = 1'b0;
    logic        stall_req = 1'b0;
    logic [31:0] master_clk;
    logic        acc_done, acc_ready, dot_en;

    int n_checks = 0;
    int n_fail   = 0;
    int dot_err  = 0;
    int dot_seen = 0;
    int wd       = 0;
    logic [31:0] prev_m = '0;

    bus_cycle_timer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_addr   (acc_addr),
        .fast_rom   (fast_rom),
        .stall_req  (stall_req),
        .master_clk (master_clk),
        .acc_done   (acc_done),
        .acc_ready  (acc_ready),
        .dot_en     (dot_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R7 monitor: dot enable expected after a step onto a multiple of 4
    always @(negedge clk) begin
        if (rst_n) begin
            logic e;
            e = (master_clk != prev_m) && (master_clk[1:0] == 2'b00);
            if (dot_en != e) dot_err++;
            if (dot_en) dot_seen++;
        end
        prev_m = master_clk;
    end

    // watchdog
    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=<20000", wd);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    // wait for acc_done; returns the number of falling edges seen
    task automatic wait_done(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            acc_valid = 1'b0;
        end while (!acc_done && cyc < 20);
    endtask

    initial begin
        int          cyc;
        logic [31:0] m0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 master_clk", master_clk, 0);
        check("R1 acc_ready", acc_ready, 1);
        check("R1 acc_done", acc_done, 0);
        check("R1 dot_en", dot_en, 0);

        // table walk: R2..R5 lengths, R6 timing, R8 back-to-back
        for (int i = 0; i < NVEC; i++) begin
            int n;
            n         = int'(VECS[i][7:0]);
            fast_rom  = VECS[i][32];
            acc_addr  = VECS[i][31:8];
            check("R8 ready before vector", acc_ready, 1);
            m0        = master_clk;
            acc_valid = 1'b1;
            wait_done(cyc);
            $display("vector %0d addr=%h fast=%0d", i, VECS[i][31:8], VECS[i][32]);
            check("R6 table cycles to done", cyc, n / 2);
            check("R6 table master delta", master_clk - m0, n);
        end

        // R10 idle hold
        m0 = master_clk;
        repeat (5) @(negedge clk);
        check("R10 idle master stable", master_clk, m0);
        check("R6 done is one cycle", acc_done, 0);

        // R8 captured address: change addr/fast during a 12-cycle access
        acc_addr  = 24'h004000;
        fast_rom  = 1'b0;
        m0        = master_clk;
        acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        acc_addr  = 24'hC00000;
        fast_rom  = 1'b1;
        cyc = 1;
        while (!acc_done && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        check("R8 captured length cycles", cyc, 6);
        check("R8 captured master delta", master_clk - m0, 12);

        // R8 request held during busy is taken only at done: two held accesses
        @(negedge clk);
        acc_addr  = 24'h002000;   // 6 cycles
        m0        = master_clk;
        acc_valid = 1'b1;
        @(negedge clk);
        acc_addr  = 24'h400000;   // 8 cycles, held while busy
        cyc = 1;
        while (!acc_done && cyc < 20) begin
            @(negedge clk);
            cyc++;
        end
        check("R8 first of held pair", cyc, 3);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
            acc_valid = 1'b0;
        end while (!acc_done && cyc < 20);
        check("R8 second of held pair cycles", cyc, 4);
        check("R8 held pair master delta", master_clk - m0, 14);

        // R9 stall with priority over a request
        @(negedge clk);
        m0        = master_clk;
        stall_req = 1'b1;
        acc_valid = 1'b1;
        acc_addr  = 24'h004000;
        @(negedge clk);
        acc_valid = 1'b0;
        check("R9 stall leaves ready", acc_ready, 0);
        check("R9 stall no done", acc_done, 0);
        repeat (2) @(negedge clk);
        check("R9 stall master delta", master_clk - m0, 6);
        stall_req = 1'b0;
        @(negedge clk);
        check("R9 recovery no step", master_clk - m0, 6);
        check("R9 ready after recovery", acc_ready, 1);
        check("R9 no access done", acc_done, 0);

        // R7 dot monitor result
        check("R7 dot enable mismatches", dot_err, 0);
        check("R7 dot enable seen", (dot_seen > 0) ? 1 : 0, 1);

        // R1 reset mid-access
        acc_addr  = 24'h004000;
        acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
        rst_n     = 1'b0;
        @(negedge clk);
        rst_n     = 1'b1;
        check("R1 reset clears master", master_clk, 0);
        check("R1 reset ready", acc_ready, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule